// File: doc/BRIEF.md
# Station-Address PROM Access Front End

This block is the bus-slave entry point of a network controller's register window. Each cycle it may accept one request: read or write, byte, word or dword. The request arrives through one of two windows, the I/O-port window or the memory-mapped window. The block classifies every request into one of three outcomes:

- it is served from a 16-byte station-address PROM held inside the block;
- it is handed on to a downstream register port;
- it is rejected.

Two control flags come from outside the block. The first selects dword I/O mode, which changes which PROM access sizes the I/O window accepts. The second enables writes to the PROM.

Read responses return one cycle after the request. Writes produce no response. A rejected read returns all ones across the width of the access. A rejected write changes nothing. Multi-byte PROM data is little-endian, and PROM byte positions wrap inside the 16 bytes.

Top module: `addr_prom_front`

## Requirements
- R1: After reset `rsp_valid` is low and PROM byte i holds byte i of `PROM_INIT` (default 0x40+i).
- R2: I/O window (`req_space`=0), offset below 0x10, `dword_mode`=0: byte accesses and even-aligned word accesses reach the PROM. Multi-byte data is little-endian, so the lowest address carries bits 7:0.
- R3: I/O window, offset below 0x10, `dword_mode`=1: only dword accesses with address bits 1:0 equal to 0 reach the PROM. Every other size or alignment is rejected.
- R4: A rejected read returns 0x000000FF for a byte, 0x0000FFFF for a word and 0xFFFFFFFF for a dword or size code 3. A PROM byte read returns zeros in bits 31:8, and a PROM word read returns zeros in bits 31:16.
- R5: A rejected write leaves every PROM byte unchanged.
- R6: A PROM write changes PROM contents only while `prom_wen` is 1. Reads are allowed regardless of `prom_wen`.
- R7: I/O window, offset 0x10 or above: word and dword accesses are forwarded with `fwd_addr` equal to the full offset. Byte accesses there are rejected and not forwarded.
- R8: Memory-mapped window (`req_space`=1) with address bit 4 clear: byte, word and dword accesses reach the PROM at index addr[3:0], at any alignment and whatever the value of `dword_mode`. Byte positions wrap modulo 16.
- R9: Memory-mapped window with address bit 4 set: word and dword accesses are forwarded with `fwd_addr` = addr[3:0]. Byte accesses there are rejected and not forwarded.
- R10: A read yields `rsp_valid` exactly one cycle later, and a write yields no response. For a forwarded read, `rsp_rdata` equals the `fwd_rdata` presented in the request cycle.
- R11: Size code 0 means byte, 1 means word, 2 means dword. Code 3 is always rejected.
- R12: A forwarded request drives `fwd_valid`, `fwd_write`, `fwd_size` and `fwd_wdata` (equal to `req_wdata`) in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_space | input | 1 | 0 = I/O-port window, 1 = memory-mapped window |
| req_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| req_addr | input | ADDR_W | Byte offset inside the window |
| req_wdata | input | 32 | Write data, little-endian |
| dword_mode | input | 1 | Dword I/O mode flag |
| prom_wen | input | 1 | PROM write enable |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| fwd_valid | output | 1 | Forwarded request strobe |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_size | output | 2 | Forwarded size code |
| fwd_addr | output | ADDR_W | Forwarded register offset |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rdata | input | 32 | Register read data, valid in the request cycle |

## Verification
The embedded assertions cover four properties on every cycle:

- the one-cycle read latency and the absence of a response to writes;
- that no byte or invalid size ever reaches the register port;
- that low offsets in either window never leak to the register port;
- that the PROM is frozen while writes are disabled.

Only the bench scenarios can show the actual data values. These include the little-endian assembly, the wrap of byte positions, the width-dependent all-ones read value, and the way `dword_mode` changes I/O legality while leaving the memory-mapped window untouched.

// File: rtl/prom_front_pkg.sv
package prom_front_pkg;

    localparam int PROM_BYTES = 16;
    localparam int IDX_W      = $clog2(PROM_BYTES);

    localparam logic [1:0] SZ_BYTE  = 2'd0;
    localparam logic [1:0] SZ_WORD  = 2'd1;
    localparam logic [1:0] SZ_DWORD = 2'd2;

    typedef enum logic [1:0] {
        TGT_REJECT = 2'd0,
        TGT_PROM   = 2'd1,
        TGT_FWD    = 2'd2
    } target_e;

    typedef struct packed {
        target_e          tgt;
        logic [IDX_W-1:0] idx;
    } route_t;

    function automatic logic [31:0] ones_for(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_WORD: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic int unsigned bytes_for(input logic [1:0] sz);
        case (sz)
            SZ_BYTE:  return 1;
            SZ_WORD:  return 2;
            SZ_DWORD: return 4;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/prom_route.sv
module prom_route
    import prom_front_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              space,
    input  logic [1:0]        size,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dword_mode,
    output route_t            route,
    output logic [ADDR_W-1:0] fwd_addr
);
    localparam int HI_W = ADDR_W - IDX_W;

    logic io_low;
    logic io_ok;
    logic multi;

    always_comb begin
        io_low    = (addr[ADDR_W-1:IDX_W] == HI_W'(0));
        multi     = (size == SZ_WORD) || (size == SZ_DWORD);
        route.tgt = TGT_REJECT;
        route.idx = addr[IDX_W-1:0];
        fwd_addr  = addr;
        if (!dword_mode)
            io_ok = (size == SZ_BYTE) || ((size == SZ_WORD) && !addr[0]);
        else
            io_ok = (size == SZ_DWORD) && (addr[1:0] == 2'b00);

        if (!space) begin
            if (io_low) begin
                if (io_ok) route.tgt = TGT_PROM;
            end else if (multi) begin
                route.tgt = TGT_FWD;
            end
        end else begin
            fwd_addr = ADDR_W'(addr[IDX_W-1:0]);
            if (!addr[IDX_W]) begin
                if (size != 2'd3) route.tgt = TGT_PROM;
            end else if (multi) begin
                route.tgt = TGT_FWD;
            end
        end
    end
endmodule

// File: rtl/prom_store.sv
module prom_store
    import prom_front_pkg::*;
#(
    parameter logic [8*PROM_BYTES-1:0] PROM_INIT = 128'h4F4E4D4C4B4A49484746454443424140
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             prom_wen,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       size,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata
);
    typedef logic [PROM_BYTES-1:0][7:0] mem_t;

    mem_t             mem_d, mem_q;
    logic [IDX_W-1:0] pos;
    int unsigned      nb;

    always_comb begin
        mem_d = mem_q;
        rdata = '0;
        nb    = bytes_for(size);
        pos   = idx;
        for (int k = 0; k < 4; k++) begin
            pos = idx + IDX_W'(k);
            if (k < nb) begin
                rdata[8*k +: 8] = mem_q[pos];
                if (wr_req && prom_wen) mem_d[pos] = wdata[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= mem_t'(PROM_INIT);
        else        mem_q <= mem_d;
    end

    AST_PROM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !prom_wen |=> $stable(mem_q)); // R6
endmodule

// File: rtl/addr_prom_front.sv
module addr_prom_front
    import prom_front_pkg::*;
#(
    parameter int                      ADDR_W    = 5,
    parameter logic [8*PROM_BYTES-1:0] PROM_INIT = 128'h4F4E4D4C4B4A49484746454443424140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_space,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              dword_mode,
    input  logic              prom_wen,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              fwd_valid,
    output logic              fwd_write,
    output logic [1:0]        fwd_size,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [31:0]       fwd_wdata,
    input  logic [31:0]       fwd_rdata
);
    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } rsp_t;

    route_t      route;
    logic [31:0] prom_rd;
    logic        prom_wr;
    rsp_t        rsp_d, rsp_q;

    prom_route #(.ADDR_W(ADDR_W)) u_route (
        .space      (req_space),
        .size       (req_size),
        .addr       (req_addr),
        .dword_mode (dword_mode),
        .route      (route),
        .fwd_addr   (fwd_addr)
    );

    assign prom_wr = req_valid && req_write && (route.tgt == TGT_PROM);

    prom_store #(.PROM_INIT(PROM_INIT)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (prom_wr),
        .prom_wen (prom_wen),
        .idx      (route.idx),
        .size     (req_size),
        .wdata    (req_wdata),
        .rdata    (prom_rd)
    );

    assign fwd_valid = req_valid && (route.tgt == TGT_FWD);
    assign fwd_write = req_write;
    assign fwd_size  = req_size;
    assign fwd_wdata = req_wdata;

    always_comb begin
        rsp_d.valid = req_valid && !req_write;
        case (route.tgt)
            TGT_PROM: rsp_d.data = prom_rd;
            TGT_FWD:  rsp_d.data = fwd_rdata;
            default:  rsp_d.data = ones_for(req_size);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    AST_READ_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid); // R10
    AST_NO_WRITE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid); // R10
    AST_FWD_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> (req_size == SZ_WORD || req_size == SZ_DWORD)); // R7
    AST_IO_LOW_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_space && req_addr < ADDR_W'(PROM_BYTES)) |-> !fwd_valid); // R2
    AST_MMIO_LOW_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space && !req_addr[IDX_W]) |-> !fwd_valid); // R8
    AST_MMIO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && req_space) |-> (fwd_addr < ADDR_W'(PROM_BYTES))); // R9
endmodule

// File: tb/addr_prom_front_tb.sv
module addr_prom_front_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 5;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              req_valid = 0, req_write = 0, req_space = 0;
    logic [1:0]        req_size = 0;
    logic [ADDR_W-1:0] req_addr = 0;
    logic [31:0]       req_wdata = 0;
    logic              dword_mode = 0, prom_wen = 0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic              fwd_valid, fwd_write;
    logic [1:0]        fwd_size;
    logic [ADDR_W-1:0] fwd_addr;
    logic [31:0]       fwd_wdata;
    logic [31:0]       fwd_rdata;

    int n_tests = 0, n_fail = 0, cycles = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // register port model: read data derived from the offset
    assign fwd_rdata = 32'hC0DE_0000 | 32'(fwd_addr);

    addr_prom_front #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .dword_mode(dword_mode), .prom_wen(prom_wen),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fwd_valid(fwd_valid),
        .fwd_write(fwd_write), .fwd_size(fwd_size), .fwd_addr(fwd_addr),
        .fwd_wdata(fwd_wdata), .fwd_rdata(fwd_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops scoreboard on each response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 64'(rsp_rdata), 64'hDEAD);
            end else begin
                check(tag_q.pop_front(), 64'(rsp_rdata), 64'(exp_q.pop_front()));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=%0d expected=<5000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic issue(input logic sp, input logic wr, input logic [1:0] sz,
                         input logic [ADDR_W-1:0] a, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_space = sp;
        req_size = sz; req_addr = a; req_wdata = wd;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd(input string tag, input logic sp, input logic [1:0] sz,
                      input logic [ADDR_W-1:0] a, input logic [31:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        issue(sp, 0, sz, a, 32'h0);
        idle();
    endtask

    task automatic wr(input logic sp, input logic [1:0] sz,
                      input logic [ADDR_W-1:0] a, input logic [31:0] d);
        issue(sp, 1, sz, a, d);
        idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);

        // word mode, I/O window
        dword_mode = 0;
        rd("R1 R2 byte 3", 0, 0, 5'h03, 32'h0000_0043);
        rd("R2 word 4 little-endian", 0, 1, 5'h04, 32'h0000_4544);
        rd("R4 odd word rejected", 0, 1, 5'h05, 32'h0000_FFFF);
        rd("R4 dword rejected in word mode", 0, 2, 5'h00, 32'hFFFF_FFFF);

        // dword mode
        dword_mode = 1;
        rd("R3 dword 8", 0, 2, 5'h08, 32'h4B4A_4948);
        rd("R3 R4 byte rejected", 0, 0, 5'h01, 32'h0000_00FF);
        rd("R3 misaligned dword rejected", 0, 2, 5'h02, 32'hFFFF_FFFF);

        // write enable
        dword_mode = 0; prom_wen = 0;
        wr(0, 0, 5'h02, 32'h99);
        rd("R6 locked write ignored", 0, 0, 5'h02, 32'h0000_0042);
        prom_wen = 1;
        wr(0, 1, 5'h06, 32'h0000_BEEF);
        rd("R6 R2 word write", 0, 1, 5'h06, 32'h0000_BEEF);

        // rejected writes
        dword_mode = 1;
        wr(0, 0, 5'h00, 32'h77);
        rd("R5 rejected byte write", 0, 2, 5'h00, 32'h4342_4140);
        rd("R11 size 3 read", 0, 3, 5'h00, 32'hFFFF_FFFF);
        wr(0, 3, 5'h04, 32'h0);
        rd("R11 R5 size 3 write ignored", 0, 2, 5'h04, 32'hBEEF_4544);

        // I/O forwarding
        exp_q.push_back(32'hC0DE_0012); tag_q.push_back("R7 R10 fwd read data");
        issue(0, 0, 1, 5'h12, 32'h0);
        check("R7 R12 fwd_valid", 64'(fwd_valid), 64'h1);
        check("R7 fwd_addr full", 64'(fwd_addr), 64'h12);
        check("R12 fwd_size", 64'(fwd_size), 64'h1);
        idle();
        exp_q.push_back(32'h0000_00FF); tag_q.push_back("R7 byte high rejected");
        issue(0, 0, 0, 5'h12, 32'h0);
        check("R7 byte not forwarded", 64'(fwd_valid), 64'h0);
        idle();
        issue(0, 1, 2, 5'h14, 32'h1234_5678);
        check("R12 fwd write strobe", 64'({fwd_valid, fwd_write}), 64'h3);
        check("R12 fwd_wdata", 64'(fwd_wdata), 64'h1234_5678);
        idle();

        // memory-mapped window, mode ignored (dword_mode still 1)
        rd("R8 mmio byte 3", 1, 0, 5'h03, 32'h0000_0043);
        rd("R8 mmio word wrap", 1, 1, 5'h0F, 32'h0000_404F);
        wr(1, 2, 5'h0E, 32'hA1B2_C3D4);
        rd("R8 wrapped dword write low", 0, 2, 5'h00, 32'h4342_A1B2);
        rd("R8 wrapped dword write high", 1, 1, 5'h0E, 32'h0000_C3D4);

        exp_q.push_back(32'hC0DE_0006); tag_q.push_back("R9 R10 mmio fwd read");
        issue(1, 0, 2, 5'h16, 32'h0);
        check("R9 mmio fwd offset", 64'({fwd_valid, fwd_addr}), 64'({1'b1, 5'h06}));
        idle();
        exp_q.push_back(32'h0000_00FF); tag_q.push_back("R9 mmio byte rejected");
        issue(1, 0, 0, 5'h16, 32'h0);
        check("R9 mmio byte not forwarded", 64'(fwd_valid), 64'h0);
        idle();
        issue(1, 1, 1, 5'h1A, 32'h0000_BEEF);
        check("R9 R12 mmio fwd write", 64'({fwd_valid, fwd_write, fwd_size, fwd_addr}),
              64'({1'b1, 1'b1, 2'd1, 5'h0A}));
        idle();

        repeat (3) @(negedge clk);
        check("R10 all responses seen", 64'(exp_q.size()), 64'h0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule